// File: doc/BRIEF.md
# Masked Rotating Lane Pattern Generator

This block is a built-in test source for a bank of serial data receivers. A 32-bit pattern circulates left by one position on every serial clock, the bit that leaves the top re-entering at the bottom, so the sequence repeats every 32 cycles. The current top bit is copied onto each output lane whose bit in a lane-select mask is set. Lanes whose mask bit is clear stay at 0.

While the generator runs, a per-lane multiplexer feeds the generated lanes to the receivers in place of the external serial inputs. While it is stopped, the external inputs pass straight through. Host writes to the pattern and the mask always land in holding registers. The running copy is frozen while the generator runs, so a new pattern or mask takes effect only on the next start after a stop.

Top module: `lane_pattern_gen`

## Requirements
- R1: After reset the generator is stopped, the pattern and mask hold 0, `gen_lanes` is all zero and `rx_lanes` equals `ser_in`.
- R2: While stopped, `gen_lanes` is all zero and `rx_lanes` follows `ser_in` in the same cycle. Writes to the pattern and mask do not change either output.
- R3: A start request (`gen_en_we`=1, `gen_en_wdata`=1) while stopped starts the generator from the next cycle. The first output bit is bit 31 of the held pattern.
- R4: In the k-th cycle of a run (k=0 first), the output bit is pattern bit 31-(k mod 32). This is a left rotation with the old top bit moving into bit 0, and the sequence repeats every 32 cycles.
- R5: While running, lane n carries the output bit when mask bit n is set and 0 when it is clear. An all-ones mask drives all 24 lanes.
- R6: While running, `rx_lanes` equals `gen_lanes`, and `ser_in` has no effect on it.
- R7: Pattern or mask writes made while running leave the running pattern and mask unchanged. They are held and used from the next start after a stop.
- R8: A start request while already running has no effect, and the rotation continues without restarting.
- R9: A stop request (`gen_en_we`=1, `gen_en_wdata`=0) while running returns the block to pass-through from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pat_we | input | 1 | Pattern write strobe |
| cfg_pat_wdata | input | 32 | Pattern write value |
| cfg_mask_we | input | 1 | Lane mask write strobe |
| cfg_mask_wdata | input | 24 | Lane mask write value; bit n selects lane n |
| gen_en_we | input | 1 | Run control write strobe |
| gen_en_wdata | input | 1 | 1 requests start, 0 requests stop |
| ser_in | input | 24 | External serial inputs |
| rx_lanes | output | 24 | Lanes delivered to the receivers |
| gen_lanes | output | 24 | Generated lanes after masking |

## Verification
The assertions assume that each control input holds a defined level at every clock edge. They also assume that a pattern or mask write in the same cycle as a start request does not need to reach that run, because the run loads the value held before that edge. The stimulus drives all inputs on the falling edge and keeps pattern and mask writes at least one cycle away from a start request. It does issue writes and repeated start requests in the middle of a run, so that freezing and ignoring can be observed at the lanes.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int PAT_W = 32,
  parameter int LANES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pat_we,
  input  logic [PAT_W-1:0] cfg_pat_wdata,
  input  logic             cfg_mask_we,
  input  logic [LANES-1:0] cfg_mask_wdata,
  input  logic             gen_en_we,
  input  logic             gen_en_wdata,
  input  logic [LANES-1:0] ser_in,
  output logic [LANES-1:0] rx_lanes,
  output logic [LANES-1:0] gen_lanes
);

  logic [PAT_W-1:0] pat_sh, rot;
  logic [LANES-1:0] mask_sh, mask_act;
  logic             en_q;

  wire start_req = gen_en_we & gen_en_wdata;
  wire stop_req  = gen_en_we & ~gen_en_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_sh  <= '0;
      mask_sh <= '0;
    end else begin
      if (cfg_pat_we)  pat_sh  <= cfg_pat_wdata;
      if (cfg_mask_we) mask_sh <= cfg_mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   en_q <= 1'b0;
    else if (!en_q && start_req)  en_q <= 1'b1;
    else if (en_q && stop_req)    en_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot      <= '0;
      mask_act <= '0;
    end else if (!en_q) begin
      rot      <= pat_sh;
      mask_act <= mask_sh;
    end else begin
      rot      <= {rot[PAT_W-2:0], rot[PAT_W-1]};
    end
  end

  assign gen_lanes = en_q ? (mask_act & {LANES{rot[PAT_W-1]}}) : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_mux
    assign rx_lanes[i] = en_q ? gen_lanes[i] : ser_in[i];
  end

endmodule

module lane_pattern_gen_chk #(
  parameter int PAT_W = 32,
  parameter int LANES = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en_we,
  input logic             gen_en_wdata,
  input logic             en_q,
  input logic [PAT_W-1:0] rot,
  input logic [PAT_W-1:0] pat_sh,
  input logic [LANES-1:0] mask_act,
  input logic [LANES-1:0] mask_sh,
  input logic [LANES-1:0] ser_in,
  input logic [LANES-1:0] rx_lanes,
  input logic [LANES-1:0] gen_lanes
);

  assert_idle_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (gen_lanes == '0) && (rx_lanes == ser_in));

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && gen_en_we && gen_en_wdata) |=>
      en_q && (rot == $past(pat_sh)) && (mask_act == $past(mask_sh)));

  assert_rotate_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(gen_en_we && !gen_en_wdata)) |=>
      en_q && $stable(mask_act) &&
      (rot == {$past(rot[PAT_W-2:0]), $past(rot[PAT_W-1])}));

  assert_mask_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ((gen_lanes & ~mask_act) == '0) && (rx_lanes == gen_lanes));

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && gen_en_we && !gen_en_wdata) |=> !en_q);

endmodule

bind lane_pattern_gen lane_pattern_gen_chk #(.PAT_W(PAT_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en_we(gen_en_we), .gen_en_wdata(gen_en_wdata),
  .en_q(en_q), .rot(rot), .pat_sh(pat_sh), .mask_act(mask_act), .mask_sh(mask_sh),
  .ser_in(ser_in), .rx_lanes(rx_lanes), .gen_lanes(gen_lanes)
);

// File: tb/sim_lane_pattern_gen.sv
`timescale 1ns/1ps
module sim_lane_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pat_we = 1'b0;
  logic [31:0] cfg_pat_wdata = '0;
  logic        cfg_mask_we = 1'b0;
  logic [23:0] cfg_mask_wdata = '0;
  logic        gen_en_we = 1'b0;
  logic        gen_en_wdata = 1'b0;
  logic [23:0] ser_in = '0;
  logic [23:0] rx_lanes, gen_lanes;

  int checks = 0, failures = 0;

  logic [31:0] m_pat, m_wpat;
  logic [23:0] m_mask, m_wmask;
  bit          m_en;
  int          m_k;

  always #5 clk = ~clk;

  lane_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pat_we(cfg_pat_we), .cfg_pat_wdata(cfg_pat_wdata),
    .cfg_mask_we(cfg_mask_we), .cfg_mask_wdata(cfg_mask_wdata),
    .gen_en_we(gen_en_we), .gen_en_wdata(gen_en_wdata),
    .ser_in(ser_in), .rx_lanes(rx_lanes), .gen_lanes(gen_lanes)
  );

  task automatic model_edge();
    logic [31:0] old_pat = m_pat;
    logic [23:0] old_mask = m_mask;
    if (!rst_n) begin
      m_pat = '0; m_mask = '0; m_wpat = '0; m_wmask = '0; m_en = 0; m_k = 0;
      return;
    end
    if (cfg_pat_we)  m_pat  = cfg_pat_wdata;
    if (cfg_mask_we) m_mask = cfg_mask_wdata;
    if (!m_en) begin
      m_wpat = old_pat; m_wmask = old_mask; m_k = 0;
      if (gen_en_we && gen_en_wdata) m_en = 1;
    end else begin
      m_k++;
      if (gen_en_we && !gen_en_wdata) m_en = 0;
    end
  endtask

  task automatic tick(input string tag);
    logic [23:0] exp_gen, exp_rx;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_gen = (m_en && m_wpat[31 - (m_k % 32)]) ? m_wmask : 24'h0;
    exp_rx  = m_en ? exp_gen : ser_in;
    checks++;
    if (gen_lanes !== exp_gen || rx_lanes !== exp_rx) begin
      failures++;
      $display("FAIL %s gen=%h rx=%h expected gen=%h rx=%h", tag, gen_lanes, rx_lanes, exp_gen, exp_rx);
    end
    cfg_pat_we = 0; cfg_mask_we = 0; gen_en_we = 0;
    ser_in = 24'($urandom);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr_pat(input logic [31:0] v);
    cfg_pat_we = 1; cfg_pat_wdata = v;
  endtask
  task automatic wr_mask(input logic [23:0] v);
    cfg_mask_we = 1; cfg_mask_wdata = v;
  endtask
  task automatic wr_en(input bit v);
    gen_en_we = 1; gen_en_wdata = v;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    run("R1", 3);
    rst_n = 1;
    run("R1", 2);
    wr_pat(32'hA5C3_0F17); tick("R2");
    wr_mask(24'hFF_FFFF);  tick("R2");
    run("R2", 4);
    wr_en(1); tick("R3");
    run("R4", 70);
    wr_en(0); tick("R9");
    run("R9", 2);
    wr_mask(24'h00_A5F0); tick("R2");
    wr_pat(32'h8000_0001); tick("R2");
    wr_en(1); tick("R3");
    run("R5", 35);
    run("R6", 10);
    wr_pat(32'h0F0F_3C3C); tick("R7");
    wr_mask(24'h12_3456);  tick("R7");
    run("R7", 20);
    wr_en(1); tick("R8");
    run("R8", 10);
    wr_en(1); tick("R8");
    run("R8", 5);
    wr_en(0); tick("R9");
    run("R9", 3);
    wr_en(1); tick("R7");
    run("R7", 40);
    wr_mask(24'h80_0001); tick("R5");
    wr_en(0); tick("R9");
    tick("R5");
    wr_en(1); tick("R5");
    run("R5", 33);
    wr_en(0); tick("R9");
    run("R2", 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule